// File: doc/BRIEF.md
# Task-Driven Capture/Compare Timer

This block is a timer/counter peripheral on a plain 32-bit register bus. Software does not write a control word to start or stop it. It writes a one into a task address, and that write acts as a single-cycle command: run, halt, step, zero, or snapshot the count into a channel. Each compare channel holds a value. When the running count steps onto that value, the channel raises a sticky flag that software reads and later clears by writing zero. A per-channel mask folds these flags into one interrupt line.

The count source is either a tick from a power-of-two prescaler or the step task. The tick rate is a fixed base rate divided by 2^n, and the base rate is itself `TICK_DIV` core clocks. The count wraps at a selectable width of 8, 16, 24 or 32 bits. Per-channel link bits make a compare hit zero the count or halt it in hardware, so a periodic or one-shot timer runs with no software in the loop. The number of channels is a parameter. Addresses that belong to channels above that number have no effect and read as zero.

Top module: `tick_cmp_timer`

## Requirements
- R1: After reset, every configuration field, compare value, flag and mask bit reads 0, the count is 0 and stopped, and `irq` is low.
- R2: Writing bit 0 = 1 to 0x000 sets the run state. Writing bit 0 = 1 to 0x004 clears it. While the block is stopped, the count does not advance.
- R3: With mode 0 in field 0x504[1:0], a running count advances once per tick. A tick occurs every `TICK_DIV`·2^p clocks, where p is the 4-bit value at 0x510, limited to 9. The field reads back exactly as written, and writing it restarts the tick phase.
- R4: With mode 1 or 2, a running count advances by one for each write of bit 0 = 1 to 0x008 and ignores ticks.
- R5: Field 0x508[1:0] sets the count width: 0 = 16, 1 = 8, 2 = 24 and 3 = 32 bits. The count wraps from all-ones to 0 at that width.
- R6: Writing bit 0 = 1 to 0x00C sets the count to 0 on the next clock and leaves the run state as it was.
- R7: Writing bit 0 = 1 to 0x040 + 4·x copies the current count into the compare value of channel x. That value can also be written and read directly at 0x540 + 4·x.
- R8: The flag of channel x reads 1 at bit 0 of 0x140 + 4·x from the clock after the count steps onto that channel's compare value. Writing 0 clears the flag and a nonzero write is ignored. A new hit in the same cycle as a write of 0 leaves the flag set.
- R9: In the link register at 0x200, bit x makes a hit on channel x zero the count, and bit 8+x makes it halt the count. A halt link freezes the count at the compare value.
- R10: Writing ones to bits 16+x at 0x304 sets mask bits, and writing ones at 0x308 clears them. Both addresses read the mask at bits 16+x. `irq` is high when some channel has both its flag and its mask bit set.
- R11: For a channel index at or above `NUM_CH`, writes to its addresses, link bits and mask bits have no effect, and all of them read 0.
- R12: A hit needs the count to have just stepped. Writing a compare value equal to the count, or zeroing the count, raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 12 | Byte address of the register access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | OR over channels of flag AND mask |

## Verification
The sharpest corner is the race between a software clear and a new hit. The bench writes zero to a flag every cycle while a zero link gives a period of four ticks, and it counts how often the flag survives. A design that lets the clear win shows no survivors, and a wrong period gives a count other than five. The bench also snapshots the count after a halt link fires: an increment that slips through on the halting edge leaves 11 instead of 10. It measures tick spacing at several prescaler settings, including an out-of-range one that must act as 9. Further checks cover wrap at 8 bits, writes of a compare value equal to the count, and channel and mask bits above `NUM_CH`. These show up as wrong snapshot values, spurious flags and stray read-back bits.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 12;
  localparam int CH_IDX_W = 3;

  // single-word task and configuration addresses
  localparam logic [ADDR_W-1:0] OFS_GO      = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_HALT    = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_BUMP    = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_ZERO    = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_LINK    = 12'h200;
  localparam logic [ADDR_W-1:0] OFS_IEN_SET = 12'h304;
  localparam logic [ADDR_W-1:0] OFS_IEN_CLR = 12'h308;
  localparam logic [ADDR_W-1:0] OFS_MODE    = 12'h504;
  localparam logic [ADDR_W-1:0] OFS_SPAN    = 12'h508;
  localparam logic [ADDR_W-1:0] OFS_DIV     = 12'h510;

  // 32-byte regions holding one word per channel, selected by addr[11:5]
  localparam logic [6:0] RGN_SNAP = 7'h02;
  localparam logic [6:0] RGN_HIT  = 7'h0A;
  localparam logic [6:0] RGN_CMP  = 7'h2A;

  localparam int LINK_HALT_LSB = 8;
  localparam int IEN_LSB       = 16;
  localparam int DIV_MAX       = 9;

  function automatic logic [WORD_W-1:0] span_mask(input logic [1:0] sel);
    case (sel)
      2'd0:    return 32'h0000_FFFF;
      2'd1:    return 32'h0000_00FF;
      2'd2:    return 32'h00FF_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int TICK_DIV = 1,
  parameter int PRE_MAX  = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] pre,
  input  logic       restart,
  output logic       tick
);
  localparam int DIV_W = $clog2(TICK_DIV) + PRE_MAX + 1;

  logic [DIV_W-1:0] div_q, div_d, limit;
  logic [3:0]       pre_eff;

  always_comb begin
    pre_eff = (pre > 4'(PRE_MAX)) ? 4'(PRE_MAX) : pre;
    limit   = (DIV_W'(TICK_DIV) << pre_eff) - DIV_W'(1);
    tick    = (div_q == limit);
    if (restart || tick) div_d = '0;
    else                 div_d = div_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bump,
  input  logic              go,
  input  logic              halt,
  input  logic              zero,
  input  logic              link_zero,
  input  logic              link_halt,
  input  logic [1:0]        mode,
  input  logic [1:0]        span,
  output logic [WORD_W-1:0] cnt_q,
  output logic              run_q,
  output logic              adv_q
);
  logic [WORD_W-1:0] cnt_d;
  logic              run_d, adv_d, step, wipe, src;

  always_comb begin
    case (mode)
      2'd0:       src = tick;
      2'd1, 2'd2: src = bump;
      default:    src = 1'b0;
    endcase
    step  = run_q && !link_halt && src;
    wipe  = zero || link_zero;
    run_d = run_q;
    if (go)                run_d = 1'b1;
    if (halt || link_halt) run_d = 1'b0;
    if (wipe)      cnt_d = '0;
    else if (step) cnt_d = (cnt_q + WORD_W'(1)) & span_mask(span);
    else           cnt_d = cnt_q & span_mask(span);
    adv_d = step && !wipe;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      adv_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
      adv_q <= adv_d;
    end
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_we,
  input  logic              snap,
  input  logic              hit_we,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] cnt,
  input  logic              adv,
  input  logic [1:0]        span,
  output logic [WORD_W-1:0] cmp_q,
  output logic              flag_q,
  output logic              match
);
  logic [WORD_W-1:0] cmp_d;
  logic              flag_d;

  always_comb begin
    match = adv && (cnt == (cmp_q & span_mask(span)));
    flag_d = flag_q;
    if (hit_we && (wdata == '0)) flag_d = 1'b0;
    if (match)                   flag_d = 1'b1;
    cmp_d = cmp_q;
    if (cmp_we) cmp_d = wdata;
    if (snap)   cmp_d = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (snap || cmp_we) cmp_q <= cmp_d;
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer
  import tmr_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int TICK_DIV = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              irq
);
  logic [1:0] rs_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  // decode
  logic                go_s, halt_s, bump_s, zero_s;
  logic                in_snap, in_hit, in_cmp, div_wr;
  logic [CH_IDX_W-1:0] ch_idx;

  always_comb begin
    go_s    = bus_we && (bus_addr == OFS_GO)   && bus_wdata[0];
    halt_s  = bus_we && (bus_addr == OFS_HALT) && bus_wdata[0];
    bump_s  = bus_we && (bus_addr == OFS_BUMP) && bus_wdata[0];
    zero_s  = bus_we && (bus_addr == OFS_ZERO) && bus_wdata[0];
    div_wr  = bus_we && (bus_addr == OFS_DIV);
    in_snap = (bus_addr[11:5] == RGN_SNAP);
    in_hit  = (bus_addr[11:5] == RGN_HIT);
    in_cmp  = (bus_addr[11:5] == RGN_CMP);
    ch_idx  = bus_addr[4:2];
  end

  // configuration registers
  logic [NUM_CH-1:0] link_clr_q, link_clr_d, link_hlt_q, link_hlt_d;
  logic [NUM_CH-1:0] ien_q, ien_d;
  logic [1:0]        mode_q, mode_d, span_q, span_d;
  logic [3:0]        div_q, div_d;
  logic              cfg_en;

  always_comb begin
    link_clr_d = link_clr_q;
    link_hlt_d = link_hlt_q;
    ien_d      = ien_q;
    mode_d     = mode_q;
    span_d     = span_q;
    div_d      = div_q;
    cfg_en     = 1'b0;
    if (bus_we) begin
      case (bus_addr)
        OFS_LINK: begin
          link_clr_d = bus_wdata[0 +: NUM_CH];
          link_hlt_d = bus_wdata[LINK_HALT_LSB +: NUM_CH];
          cfg_en     = 1'b1;
        end
        OFS_IEN_SET: begin
          ien_d  = ien_q | bus_wdata[IEN_LSB +: NUM_CH];
          cfg_en = 1'b1;
        end
        OFS_IEN_CLR: begin
          ien_d  = ien_q & ~bus_wdata[IEN_LSB +: NUM_CH];
          cfg_en = 1'b1;
        end
        OFS_MODE: begin mode_d = bus_wdata[1:0]; cfg_en = 1'b1; end
        OFS_SPAN: begin span_d = bus_wdata[1:0]; cfg_en = 1'b1; end
        OFS_DIV:  begin div_d  = bus_wdata[3:0]; cfg_en = 1'b1; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      link_clr_q <= '0;
      link_hlt_q <= '0;
      ien_q      <= '0;
      mode_q     <= '0;
      span_q     <= '0;
      div_q      <= '0;
    end else if (cfg_en) begin
      link_clr_q <= link_clr_d;
      link_hlt_q <= link_hlt_d;
      ien_q      <= ien_d;
      mode_q     <= mode_d;
      span_q     <= span_d;
      div_q      <= div_d;
    end
  end

  // datapath
  logic              tick;
  logic [WORD_W-1:0] cnt_q;
  logic              run_q, adv_q;
  logic [NUM_CH-1:0] evt_v, hit_v;
  logic [WORD_W-1:0] cmp_v [NUM_CH];

  tmr_tick_gen #(.TICK_DIV(TICK_DIV), .PRE_MAX(DIV_MAX)) u_tick (
    .clk(clk), .rst_n(srst_n), .pre(div_q), .restart(div_wr), .tick(tick)
  );

  tmr_counter u_cnt (
    .clk(clk), .rst_n(srst_n), .tick(tick), .bump(bump_s), .go(go_s),
    .halt(halt_s), .zero(zero_s),
    .link_zero(|(hit_v & link_clr_q)), .link_halt(|(hit_v & link_hlt_q)),
    .mode(mode_q), .span(span_q), .cnt_q(cnt_q), .run_q(run_q), .adv_q(adv_q)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic sel;
    assign sel = (ch_idx == CH_IDX_W'(i));
    tmr_channel u_ch (
      .clk(clk), .rst_n(srst_n),
      .cmp_we(bus_we && in_cmp && sel),
      .snap(bus_we && in_snap && sel && bus_wdata[0]),
      .hit_we(bus_we && in_hit && sel),
      .wdata(bus_wdata), .cnt(cnt_q), .adv(adv_q), .span(span_q),
      .cmp_q(cmp_v[i]), .flag_q(evt_v[i]), .match(hit_v[i])
    );
  end

  assign irq = |(evt_v & ien_q);

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_LINK: begin
        bus_rdata[0 +: NUM_CH]             = link_clr_q;
        bus_rdata[LINK_HALT_LSB +: NUM_CH] = link_hlt_q;
      end
      OFS_IEN_SET, OFS_IEN_CLR: bus_rdata[IEN_LSB +: NUM_CH] = ien_q;
      OFS_MODE: bus_rdata[1:0] = mode_q;
      OFS_SPAN: bus_rdata[1:0] = span_q;
      OFS_DIV:  bus_rdata[3:0] = div_q;
      default: ;
    endcase
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_idx == CH_IDX_W'(i)) begin
        if (in_hit) bus_rdata = {{(WORD_W-1){1'b0}}, evt_v[i]};
        if (in_cmp) bus_rdata = cmp_v[i];
      end
    end
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [WORD_W-1:0] bus_wdata,
  input logic [WORD_W-1:0] cnt,
  input logic              run,
  input logic              adv,
  input logic [NUM_CH-1:0] evt,
  input logic [NUM_CH-1:0] mask,
  input logic [1:0]        wsel,
  input logic              irq
);
  logic zero_wr, halt_wr;
  assign zero_wr = bus_we && (bus_addr == OFS_ZERO) && bus_wdata[0];
  assign halt_wr = bus_we && (bus_addr == OFS_HALT) && bus_wdata[0];

  // R6
  zero_task_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_wr |=> (cnt == '0));

  // R2
  halt_task_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_wr |=> !run);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !adv && !zero_wr) |=> $stable(cnt));

  // R5
  narrow_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wsel == 2'd1 && $past(wsel) == 2'd1) |-> (cnt[WORD_W-1:8] == '0));

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_flag
    // R8
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(evt[i]) |-> $past(adv));
  end
endmodule

bind tick_cmp_timer tmr_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .cnt(cnt_q), .run(run_q), .adv(adv_q),
  .evt(evt_v), .mask(ien_q), .wsel(span_q), .irq(irq)
);

// File: tb/sim_tick_cmp_timer.sv
`timescale 1ns/1ps
module sim_tick_cmp_timer;
  localparam logic [11:0] A_GO = 12'h000, A_HALT = 12'h004, A_BUMP = 12'h008,
                          A_ZERO = 12'h00C, A_LINK = 12'h200,
                          A_MSET = 12'h304, A_MCLR = 12'h308, A_MODE = 12'h504,
                          A_SPAN = 12'h508, A_DIV = 12'h510;

  function automatic logic [11:0] a_snap(input int x); return 12'h040 + 12'(4*x); endfunction
  function automatic logic [11:0] a_hit(input int x);  return 12'h140 + 12'(4*x); endfunction
  function automatic logic [11:0] a_cmp(input int x);  return 12'h540 + 12'(4*x); endfunction

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  tick_cmp_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [31:0] exp;
    bit          is_irq;
    string       tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  logic     rd_vld = 1'b0;
  int       n_chk = 0;
  int       n_err = 0;

  // monitor: pops one expectation per read strobe
  always @(negedge clk) begin
    if (rd_vld) begin
      sb_item_t it;
      logic [31:0] act;
      it  = sb_q.pop_front();
      act = it.is_irq ? {31'b0, irq} : bus_rdata;
      n_chk++;
      if (act !== it.exp) begin
        n_err++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push_rd(input logic [11:0] a, input logic [31:0] exp, input bit is_irq,
                         input string tag);
    sb_item_t it;
    bus_addr = a;
    @(posedge clk); #1;
    it.exp = exp; it.is_irq = is_irq; it.tag = tag;
    sb_q.push_back(it);
    rd_vld = 1'b1;
    @(negedge clk); #1;
    rd_vld = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    push_rd(a, exp, 1'b0, tag);
  endtask

  task automatic rd_irq(input logic exp, input string tag);
    push_rd(A_MODE, {31'b0, exp}, 1'b1, tag);
  endtask

  task automatic peek(input logic [11:0] a, output logic [31:0] v);
    bus_addr = a;
    @(posedge clk); #1;
    @(negedge clk);
    v = bus_rdata;
    #1;
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] v0, v1;
    int ones;
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    rd(A_MODE, 0, "R1 mode");
    rd(A_SPAN, 0, "R1 span");
    rd(A_DIV, 0, "R1 div");
    rd(A_LINK, 0, "R1 link");
    rd(A_MSET, 0, "R1 mask");
    rd(a_hit(0), 0, "R1 flag0");
    rd_irq(1'b0, "R1 irq");
    wr(a_snap(0), 1);
    rd(a_cmp(0), 0, "R1 count zero");

    // R4 step task, R7 snapshot
    wr(A_MODE, 1); wr(A_SPAN, 1); wr(A_GO, 1);
    for (int i = 0; i < 5; i++) wr(A_BUMP, 1);
    wr(a_snap(0), 1);
    rd(a_cmp(0), 5, "R4 R7 five steps");

    // R5 8-bit wrap
    wr(A_ZERO, 1);
    for (int i = 0; i < 255; i++) wr(A_BUMP, 1);
    wr(a_snap(1), 1);
    rd(a_cmp(1), 255, "R5 top of 8 bits");
    wr(A_BUMP, 1);
    wr(a_snap(1), 1);
    rd(a_cmp(1), 0, "R5 wrap to 0");

    // R4 mode 2 also steps on task
    wr(A_MODE, 2); wr(A_ZERO, 1);
    for (int i = 0; i < 3; i++) wr(A_BUMP, 1);
    wr(a_snap(2), 1);
    rd(a_cmp(2), 3, "R4 mode 2");

    // R2 halt and resume
    wr(A_HALT, 1); wr(A_BUMP, 1); wr(A_BUMP, 1);
    wr(a_snap(2), 1);
    rd(a_cmp(2), 3, "R2 halted");
    wr(A_GO, 1); wr(A_BUMP, 1);
    wr(a_snap(2), 1);
    rd(a_cmp(2), 4, "R2 resumed");

    // R6 zero keeps run state
    wr(A_ZERO, 1); wr(A_BUMP, 1);
    wr(a_snap(2), 1);
    rd(a_cmp(2), 1, "R6 still running");
    wr(A_HALT, 1); wr(A_ZERO, 1); wr(A_BUMP, 1);
    wr(a_snap(2), 1);
    rd(a_cmp(2), 0, "R6 still halted");

    // R12, R8, R10 flags and mask
    for (int i = 0; i < 4; i++) wr(a_hit(i), 0);
    wr(a_cmp(3), 0);
    rd(a_hit(3), 0, "R12 equal write no flag");
    wr(A_GO, 1);
    wr(a_cmp(2), 3);
    wr(A_MSET, 32'h0004_0000);
    for (int i = 0; i < 3; i++) wr(A_BUMP, 1);
    rd(a_hit(2), 1, "R8 flag set");
    rd_irq(1'b1, "R10 irq on");
    wr(A_BUMP, 1);
    rd(a_hit(2), 1, "R8 sticky");
    wr(a_hit(2), 1);
    rd(a_hit(2), 1, "R8 nonzero write ignored");
    wr(a_hit(2), 0);
    rd(a_hit(2), 0, "R8 cleared");
    rd_irq(1'b0, "R10 irq off");
    wr(A_MSET, 32'h003F_0000);
    rd(A_MSET, 32'h000F_0000, "R11 mask above channels");
    wr(A_MCLR, 32'h0001_0000);
    rd(A_MCLR, 32'h000E_0000, "R10 mask clear");
    wr(A_BUMP, 1);
    rd(a_hit(0), 1, "R8 flag0");
    rd_irq(1'b0, "R10 masked flag");
    wr(A_MCLR, 32'hFFFF_FFFF);
    for (int i = 0; i < 4; i++) wr(a_hit(i), 0);

    // R11 absent channels
    wr(a_cmp(5), 32'h55);
    rd(a_cmp(5), 0, "R11 cmp5");
    wr(a_snap(4), 1);
    rd(a_cmp(4), 0, "R11 snap4");
    wr(A_LINK, 32'h3F3F);
    rd(A_LINK, 32'h0F0F, "R11 R9 link bits");
    wr(A_LINK, 0);

    // R9 zero link + R8 hit beats clear
    wr(A_HALT, 1); wr(A_MODE, 0); wr(A_SPAN, 0); wr(A_DIV, 0);
    wr(a_cmp(0), 3); wr(A_LINK, 1); wr(A_ZERO, 1); wr(A_GO, 1);
    idle(10);
    bus_addr = a_hit(0); bus_wdata = 0; bus_we = 1'b1;
    @(posedge clk);
    ones = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      ones += int'(bus_rdata[0]);
    end
    #1 bus_we = 1'b0;
    chk(32'(ones), 5, "R8 R9 hit wins over clear, period 4");

    // R9 halt link freezes at compare value
    wr(A_LINK, 32'h0000_0200);
    wr(a_cmp(1), 10);
    wr(A_ZERO, 1);
    idle(30);
    wr(a_snap(2), 1);
    rd(a_cmp(2), 10, "R9 halt link");

    // R3 prescaler
    wr(A_LINK, 0); wr(A_DIV, 2); wr(A_ZERO, 1); wr(A_GO, 1);
    idle(3);
    wr(a_snap(0), 1); idle(14); wr(a_snap(1), 1);
    peek(a_cmp(0), v0); peek(a_cmp(1), v1);
    chk(v1 - v0, 4, "R3 div 2");
    wr(A_DIV, 0);
    wr(a_snap(0), 1); idle(14); wr(a_snap(1), 1);
    peek(a_cmp(0), v0); peek(a_cmp(1), v1);
    chk(v1 - v0, 16, "R3 div 0");
    wr(A_DIV, 15);
    rd(A_DIV, 15, "R3 div readback");
    wr(a_snap(0), 1); idle(1022); wr(a_snap(1), 1);
    peek(a_cmp(0), v0); peek(a_cmp(1), v1);
    chk(v1 - v0, 2, "R3 div clamp");

    idle(4);
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule